// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits between one bus master and a downstream memory port and decides, for each request, whether the request may pass and with which security tag. For every accepted request it asks an external attribution lookup about the request address. The lookup answers over a combinational port with two flags: whether the address is exempt from checking, and whether it lies in a non-secure region. Two configuration inputs complete the decision. One says whether the master is non-secure, and one selects how a refused request ends: an error response, or a silent read-as-zero / write-ignored completion.

Each request ends in exactly one of four ways. It can be refused with an error, refused silently, forwarded tagged secure, or forwarded tagged non-secure. Forwarded requests keep their address, direction, size and write data, and the downstream response is handed back unchanged. A refusal with an error also raises a sticky, level interrupt. A clear input wipes the interrupt and, while it is high, stops new refusals from setting it. The master port and the downstream port both use a valid/ready request handshake and allow one request in flight.

Top module: `msec_filter`

## Requirements
- R1: A request to an exempt address is forwarded. `dn_secure_o` is 1 (secure) when the registered master-non-secure setting is 0, and 0 (non-secure) when it is 1.
- R2: A request to an address that is not exempt and is reported non-secure is always forwarded with `dn_secure_o` = 0, whatever the configuration.
- R3: A request to a secure address (neither exempt nor non-secure) from a master configured secure is forwarded with `dn_secure_o` = 1.
- R4: A request to a secure address from a non-secure master, with the error-mode setting 0, is never sent downstream. The cycle after acceptance it completes with `up_err_o` = 0, and for a read `up_rdata_o` = 0.
- R5: The same refusal with the error-mode setting 1 completes the cycle after acceptance with `up_err_o` = 1 and is never sent downstream.
- R6: An error-mode refusal sets the interrupt status, which appears on `irq_o` together with the error response and then stays at 1 until a clear or a reset.
- R7: `irq_clr_i` is registered. Two clock edges after it is sampled high, `irq_o` is 0, and no refusal accepted while the registered clear is high sets the status.
- R8: A silent (read-as-zero / write-ignored) refusal never sets the interrupt status.
- R9: Synchronous reset clears the interrupt status, the registered configuration and the clear latch, and returns both ports to idle: `up_ready_o` = 1, `up_rvalid_o` = 0, `dn_valid_o` = 0.
- R10: `lk_addr_o` follows `up_addr_i`. A forwarded request keeps its address, direction, write data and size code (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 bytes, little-endian). The downstream `dn_err_i` and `dn_rdata_i` come back on `up_err_o` and `up_rdata_o` one cycle after `dn_rvalid_i`.
- R11: Only one request is in flight. `up_ready_o` stays 0 from acceptance until the response cycle has passed, and `dn_valid_o` and the downstream request fields hold steady until `dn_ready_i` is seen.
- R12: The configuration inputs `mst_ns_i` and `err_mode_i` are registered. A request uses the values sampled at the clock edge before its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mst_ns_i | input | 1 | Master is non-secure |
| err_mode_i | input | 1 | 1: refusals end in error; 0: read-as-zero / write-ignored |
| irq_clr_i | input | 1 | Interrupt clear, level |
| irq_o | output | 1 | Sticky violation interrupt, level |
| up_valid_i | input | 1 | Master request valid |
| up_ready_o | output | 1 | Filter can accept a request |
| up_write_i | input | 1 | 1 = write, 0 = read |
| up_addr_i | input | AW | Request address |
| up_size_i | input | 2 | Size code |
| up_wdata_i | input | DW | Write data |
| up_rvalid_o | output | 1 | Response valid, one cycle |
| up_err_o | output | 1 | Response is an error |
| up_rdata_o | output | DW | Read data |
| lk_addr_o | output | AW | Address presented to the attribution lookup |
| lk_exempt_i | input | 1 | Lookup: address exempt |
| lk_ns_i | input | 1 | Lookup: address non-secure |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream accepts request |
| dn_write_o | output | 1 | Downstream direction |
| dn_addr_o | output | AW | Downstream address |
| dn_size_o | output | 2 | Downstream size code |
| dn_wdata_o | output | DW | Downstream write data |
| dn_secure_o | output | 1 | Security tag, 1 = secure |
| dn_rvalid_i | input | 1 | Downstream response valid |
| dn_err_i | input | 1 | Downstream response error |
| dn_rdata_i | input | DW | Downstream read data |

## Verification
The assertions check the following on every cycle: the tag given to each accepted request against the lookup flags and the registered configuration, that refused requests never reach the downstream port, the one-cycle refusal response, the setting of the interrupt, its stickiness and clearing, and that the downstream request holds steady under back-pressure. Only the bench scenarios can show that every combination of lookup flags and configuration ends in the expected response seen at the master port, that downstream data and error codes come back unchanged after different downstream delays, and that reset wipes an interrupt that is already set.

// File: rtl/msf_pkg.sv
package msf_pkg;

  // Resolution of one request; bit 1 set means the request goes downstream.
  typedef enum logic [1:0] {
    ACT_BLK_ERR  = 2'd0,
    ACT_BLK_RAZ  = 2'd1,
    ACT_FWD_SEC  = 2'd2,
    ACT_FWD_NSEC = 2'd3
  } msf_act_e;

  localparam int SZ_W = 2;

  function automatic logic act_is_fwd(msf_act_e a);
    return a[1];
  endfunction

endpackage

// File: rtl/msf_decide.sv
module msf_decide
  import msf_pkg::*;
(
  input  logic     exempt_i,
  input  logic     ns_region_i,
  input  logic     mst_ns_i,
  input  logic     err_mode_i,
  output msf_act_e act_o
);

  always_comb begin
    if (exempt_i) begin
      act_o = mst_ns_i ? ACT_FWD_NSEC : ACT_FWD_SEC;
    end else if (ns_region_i) begin
      act_o = ACT_FWD_NSEC;
    end else if (!mst_ns_i) begin
      act_o = ACT_FWD_SEC;
    end else if (err_mode_i) begin
      act_o = ACT_BLK_ERR;
    end else begin
      act_o = ACT_BLK_RAZ;
    end
  end

endmodule

// File: rtl/msf_ctl.sv
module msf_ctl (
  input  logic clk,
  input  logic rst,
  input  logic mst_ns_i,
  input  logic err_mode_i,
  input  logic clr_i,
  input  logic viol_i,
  output logic mst_ns_q_o,
  output logic err_mode_q_o,
  output logic clr_q_o,
  output logic irq_o
);

  logic ns_q, em_q, clr_q, stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= 1'b0;
      em_q   <= 1'b0;
      clr_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      ns_q  <= mst_ns_i;
      em_q  <= err_mode_i;
      clr_q <= clr_i;
      if (clr_q) begin
        stat_q <= 1'b0;
      end else if (viol_i) begin
        stat_q <= 1'b1;
      end
    end
  end

  assign mst_ns_q_o   = ns_q;
  assign err_mode_q_o = em_q;
  assign clr_q_o      = clr_q;
  assign irq_o        = stat_q;

  // R6: status stays set while no clear is latched
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !clr_q) |=> stat_q);

endmodule

// File: rtl/msf_xact.sv
module msf_xact
  import msf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            up_valid_i,
  output logic            up_ready_o,
  input  logic            up_write_i,
  input  logic [AW-1:0]   up_addr_i,
  input  logic [SZ_W-1:0] up_size_i,
  input  logic [DW-1:0]   up_wdata_i,
  output logic            up_rvalid_o,
  output logic            up_err_o,
  output logic [DW-1:0]   up_rdata_o,
  input  msf_act_e        act_i,
  output logic            acc_o,
  output logic            dn_valid_o,
  input  logic            dn_ready_i,
  output logic            dn_write_o,
  output logic [AW-1:0]   dn_addr_o,
  output logic [SZ_W-1:0] dn_size_o,
  output logic [DW-1:0]   dn_wdata_o,
  output logic            dn_secure_o,
  input  logic            dn_rvalid_i,
  input  logic            dn_err_i,
  input  logic [DW-1:0]   dn_rdata_i
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_RSP} st_e;

  st_e             st_q;
  logic            wr_q, sec_q, rerr_q;
  logic [AW-1:0]   addr_q;
  logic [SZ_W-1:0] size_q;
  logic [DW-1:0]   wdata_q, rdata_q;

  assign up_ready_o = (st_q == S_IDLE);
  assign acc_o      = up_valid_i && up_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      wr_q    <= 1'b0;
      sec_q   <= 1'b0;
      rerr_q  <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (acc_o) begin
            if (act_is_fwd(act_i)) begin
              wr_q    <= up_write_i;
              addr_q  <= up_addr_i;
              size_q  <= up_size_i;
              wdata_q <= up_wdata_i;
              sec_q   <= (act_i == ACT_FWD_SEC);
              st_q    <= S_REQ;
            end else begin
              rerr_q  <= (act_i == ACT_BLK_ERR);
              rdata_q <= '0;
              st_q    <= S_RSP;
            end
          end
        end
        S_REQ: begin
          if (dn_ready_i) begin
            if (dn_rvalid_i) begin
              rerr_q  <= dn_err_i;
              rdata_q <= dn_rdata_i;
              st_q    <= S_RSP;
            end else begin
              st_q <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (dn_rvalid_i) begin
            rerr_q  <= dn_err_i;
            rdata_q <= dn_rdata_i;
            st_q    <= S_RSP;
          end
        end
        S_RSP: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign up_rvalid_o = (st_q == S_RSP);
  assign up_err_o    = rerr_q;
  assign up_rdata_o  = rdata_q;
  assign dn_valid_o  = (st_q == S_REQ);
  assign dn_write_o  = wr_q;
  assign dn_addr_o   = addr_q;
  assign dn_size_o   = size_q;
  assign dn_wdata_o  = wdata_q;
  assign dn_secure_o = sec_q;

  // R11: a stalled downstream request holds its fields
  p_dn_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (dn_valid_o && !dn_ready_i) |=>
      (dn_valid_o && $stable(dn_addr_o) && $stable(dn_secure_o) && $stable(dn_wdata_o)));

  // R11: nothing new is accepted right after an acceptance
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    acc_o |=> !up_ready_o);

  // R10: downstream response returns unchanged
  p_rsp_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_WAIT && dn_rvalid_i) |=>
      (up_rvalid_o && up_err_o == $past(dn_err_i) && up_rdata_o == $past(dn_rdata_i)));

endmodule

// File: rtl/msec_filter.sv
module msec_filter
  import msf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mst_ns_i,
  input  logic            err_mode_i,
  input  logic            irq_clr_i,
  output logic            irq_o,
  input  logic            up_valid_i,
  output logic            up_ready_o,
  input  logic            up_write_i,
  input  logic [AW-1:0]   up_addr_i,
  input  logic [1:0]      up_size_i,
  input  logic [DW-1:0]   up_wdata_i,
  output logic            up_rvalid_o,
  output logic            up_err_o,
  output logic [DW-1:0]   up_rdata_o,
  output logic [AW-1:0]   lk_addr_o,
  input  logic            lk_exempt_i,
  input  logic            lk_ns_i,
  output logic            dn_valid_o,
  input  logic            dn_ready_i,
  output logic            dn_write_o,
  output logic [AW-1:0]   dn_addr_o,
  output logic [1:0]      dn_size_o,
  output logic [DW-1:0]   dn_wdata_o,
  output logic            dn_secure_o,
  input  logic            dn_rvalid_i,
  input  logic            dn_err_i,
  input  logic [DW-1:0]   dn_rdata_i
);

  msf_act_e act;
  logic     acc, ns_q, em_q, clr_q;

  assign lk_addr_o = up_addr_i;

  msf_ctl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .mst_ns_i     (mst_ns_i),
    .err_mode_i   (err_mode_i),
    .clr_i        (irq_clr_i),
    .viol_i       (acc && act == ACT_BLK_ERR),
    .mst_ns_q_o   (ns_q),
    .err_mode_q_o (em_q),
    .clr_q_o      (clr_q),
    .irq_o        (irq_o)
  );

  msf_decide u_decide (
    .exempt_i    (lk_exempt_i),
    .ns_region_i (lk_ns_i),
    .mst_ns_i    (ns_q),
    .err_mode_i  (em_q),
    .act_o       (act)
  );

  msf_xact #(.AW(AW), .DW(DW)) u_xact (
    .clk         (clk),
    .rst         (rst),
    .up_valid_i  (up_valid_i),
    .up_ready_o  (up_ready_o),
    .up_write_i  (up_write_i),
    .up_addr_i   (up_addr_i),
    .up_size_i   (up_size_i),
    .up_wdata_i  (up_wdata_i),
    .up_rvalid_o (up_rvalid_o),
    .up_err_o    (up_err_o),
    .up_rdata_o  (up_rdata_o),
    .act_i       (act),
    .acc_o       (acc),
    .dn_valid_o  (dn_valid_o),
    .dn_ready_i  (dn_ready_i),
    .dn_write_o  (dn_write_o),
    .dn_addr_o   (dn_addr_o),
    .dn_size_o   (dn_size_o),
    .dn_wdata_o  (dn_wdata_o),
    .dn_secure_o (dn_secure_o),
    .dn_rvalid_i (dn_rvalid_i),
    .dn_err_i    (dn_err_i),
    .dn_rdata_i  (dn_rdata_i)
  );

  logic sec_blk;
  assign sec_blk = acc && !lk_exempt_i && !lk_ns_i && ns_q;

  p_exempt_tag_r1: assert property (@(posedge clk) disable iff (rst)
    (acc && lk_exempt_i) |=> (dn_valid_o && dn_secure_o == !$past(ns_q)));

  p_nsreg_tag_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && !lk_exempt_i && lk_ns_i) |=> (dn_valid_o && !dn_secure_o));

  p_sec_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && !lk_exempt_i && !lk_ns_i && !ns_q) |=> (dn_valid_o && dn_secure_o));

  p_raz_blk_r4: assert property (@(posedge clk) disable iff (rst)
    (sec_blk && !em_q) |=> (up_rvalid_o && !up_err_o && up_rdata_o == '0 && !dn_valid_o));

  p_err_blk_r5: assert property (@(posedge clk) disable iff (rst)
    (sec_blk && em_q) |=> (up_rvalid_o && up_err_o && !dn_valid_o));

  p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (sec_blk && em_q && !clr_q) |=> irq_o);

  p_clr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    irq_clr_i |-> ##2 !irq_o);

  p_raz_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (sec_blk && !em_q && !irq_o) |=> !irq_o);

  p_fwd_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (acc && act_is_fwd(act)) |=>
      (dn_addr_o == $past(up_addr_i) && dn_size_o == $past(up_size_i) &&
       dn_write_o == $past(up_write_i)));

endmodule

// File: tb/tb_msec_filter.sv
`timescale 1ns/1ps
module tb_msec_filter;

  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mst_ns_i = 0, err_mode_i = 0, irq_clr_i = 0;
  logic irq_o;
  logic up_valid_i = 0, up_write_i = 0;
  logic up_ready_o, up_rvalid_o, up_err_o;
  logic [AW-1:0] up_addr_i = '0;
  logic [1:0] up_size_i = '0;
  logic [DW-1:0] up_wdata_i = '0, up_rdata_o;
  logic [AW-1:0] lk_addr_o;
  logic lk_exempt_i = 0, lk_ns_i = 0;
  logic dn_valid_o, dn_write_o, dn_secure_o;
  logic dn_ready_i = 0, dn_rvalid_i = 0, dn_err_i = 0;
  logic [AW-1:0] dn_addr_o;
  logic [1:0] dn_size_o;
  logic [DW-1:0] dn_wdata_o, dn_rdata_i = '0;

  always #2 clk = ~clk;

  msec_filter #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .mst_ns_i(mst_ns_i), .err_mode_i(err_mode_i),
    .irq_clr_i(irq_clr_i), .irq_o(irq_o),
    .up_valid_i(up_valid_i), .up_ready_o(up_ready_o), .up_write_i(up_write_i),
    .up_addr_i(up_addr_i), .up_size_i(up_size_i), .up_wdata_i(up_wdata_i),
    .up_rvalid_o(up_rvalid_o), .up_err_o(up_err_o), .up_rdata_o(up_rdata_o),
    .lk_addr_o(lk_addr_o), .lk_exempt_i(lk_exempt_i), .lk_ns_i(lk_ns_i),
    .dn_valid_o(dn_valid_o), .dn_ready_i(dn_ready_i), .dn_write_o(dn_write_o),
    .dn_addr_o(dn_addr_o), .dn_size_o(dn_size_o), .dn_wdata_o(dn_wdata_o),
    .dn_secure_o(dn_secure_o), .dn_rvalid_i(dn_rvalid_i), .dn_err_i(dn_err_i),
    .dn_rdata_i(dn_rdata_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {exempt, ns_region, master_ns, err_mode, write, expected[1:0]}
  // expected: 0 error block, 1 silent block, 2 forward secure, 3 forward non-secure
  localparam logic [6:0] VEC [18] = '{
    7'b0000_0_10, 7'b0001_1_10, 7'b0010_0_01, 7'b0011_1_00,
    7'b0100_0_11, 7'b0101_1_11, 7'b0110_0_11, 7'b0111_1_11,
    7'b1000_0_10, 7'b1001_1_10, 7'b1010_0_11, 7'b1011_1_11,
    7'b1100_0_10, 7'b1101_1_10, 7'b1110_0_11, 7'b1111_1_11,
    7'b0010_1_01, 7'b0011_0_00
  };

  task automatic set_cfg(input logic mns, input logic em, input logic clr);
    mst_ns_i = mns; err_mode_i = em; irq_clr_i = clr;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xact(input logic [31:0] a, input logic w, input logic [1:0] sz,
                      input logic [63:0] wd, input logic ex, input logic nsr,
                      input int dlat, input logic derr, input logic [63:0] dd,
                      output logic fwd, output logic sec, output logic err,
                      output logic [63:0] rd, output logic hold_ok,
                      output logic lk_ok, output logic pass_ok);
    up_valid_i = 1; up_write_i = w; up_addr_i = a; up_size_i = sz; up_wdata_i = wd;
    lk_exempt_i = ex; lk_ns_i = nsr;
    #1;
    lk_ok = (lk_addr_o == a) && up_ready_o;
    @(negedge clk);
    up_valid_i = 0;
    fwd = dn_valid_o; sec = 0; err = 0; rd = '0; hold_ok = 1; pass_ok = 1;
    if (!fwd) begin
      hold_ok = up_rvalid_o;
      err = up_err_o; rd = up_rdata_o;
      @(negedge clk);
    end else begin
      sec = dn_secure_o;
      pass_ok = (dn_addr_o == a) && (dn_size_o == sz) && (dn_write_o == w) && (dn_wdata_o == wd);
      hold_ok = !up_ready_o && !up_rvalid_o;
      for (int k = 0; k < dlat; k++) begin
        @(negedge clk);
        hold_ok &= dn_valid_o && (dn_addr_o == a) && (dn_secure_o == sec) && !up_ready_o;
      end
      dn_ready_i = 1;
      @(negedge clk);
      dn_ready_i = 0;
      hold_ok &= !dn_valid_o && !up_rvalid_o;
      dn_rvalid_i = 1; dn_err_i = derr; dn_rdata_i = dd;
      @(negedge clk);
      dn_rvalid_i = 0; dn_err_i = 0; dn_rdata_i = '0;
      hold_ok &= up_rvalid_o;
      err = up_err_o; rd = up_rdata_o;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic fwd, sec, err, hold_ok, lk_ok, pass_ok;
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq after reset", irq_o, 0);
    chk("R9 ready after reset", up_ready_o, 1);
    chk("R9 dn_valid after reset", dn_valid_o, 0);
    chk("R9 rvalid after reset", up_rvalid_o, 0);

    for (int i = 0; i < 18; i++) begin
      logic ex, nsr, mns, em, w;
      logic [1:0] ek;
      logic [63:0] dd;
      logic derr;
      string tag;
      {ex, nsr, mns, em, w, ek} = VEC[i];
      dd = 64'hA5C3_0000_0000_0000 | 64'(i * 17 + 1);
      derr = (i % 3 == 0);
      if (ek == 2'd0) tag = "R5";
      else if (ek == 2'd1) tag = "R4";
      else if (ex) tag = "R1";
      else if (nsr) tag = "R2";
      else tag = "R3";
      set_cfg(mns, em, 0);
      xact(32'h1000_0000 + 32'(i * 8), w, 2'(i % 4), 64'hDEAD_0000_0000_0000 + 64'(i),
           ex, nsr, i % 3, derr, dd, fwd, sec, err, rd, hold_ok, lk_ok, pass_ok);
      chk({tag, " R12 forwarded"}, fwd, ek[1]);
      chk({tag, " R11 handshake"}, hold_ok, 1);
      chk("R10 lookup address", lk_ok, 1);
      if (ek[1]) begin
        chk({tag, " secure tag"}, sec, (ek == 2'd2));
        chk("R10 request fields", pass_ok, 1);
        chk("R10 response error", err, derr);
        chk("R10 response data", rd, dd);
      end else begin
        chk({tag, " block error"}, err, (ek == 2'd0));
        chk({tag, " block data"}, rd, 0);
      end
    end

    // R6 sticky after error blocks in the table
    chk("R6 irq after error blocks", irq_o, 1);
    set_cfg(0, 0, 0);
    xact(32'h2000, 0, 2'd2, 0, 0, 0, 0, 0, 64'h11, fwd, sec, err, rd, hold_ok, lk_ok, pass_ok);
    chk("R6 irq sticky over forward", irq_o, 1);

    // R7 clear
    set_cfg(1, 1, 1);
    chk("R7 irq cleared", irq_o, 0);
    xact(32'h3000, 1, 2'd3, 64'h5, 0, 0, 0, 0, 0, fwd, sec, err, rd, hold_ok, lk_ok, pass_ok);
    chk("R7 error response under clear", err, 1);
    chk("R7 no status under clear", irq_o, 0);
    set_cfg(1, 1, 0);
    chk("R7 stays clear after release", irq_o, 0);

    // R8 silent block leaves interrupt low
    set_cfg(1, 0, 0);
    xact(32'h3008, 0, 2'd0, 0, 0, 0, 0, 0, 0, fwd, sec, err, rd, hold_ok, lk_ok, pass_ok);
    chk("R8 silent block no error", err, 0);
    chk("R8 silent block irq", irq_o, 0);

    // R6 set again, R9 reset wipes it
    set_cfg(1, 1, 0);
    xact(32'h3010, 0, 2'd1, 0, 0, 0, 0, 0, 0, fwd, sec, err, rd, hold_ok, lk_ok, pass_ok);
    chk("R6 irq set by error block", irq_o, 1);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    chk("R9 reset clears irq", irq_o, 0);
    chk("R9 reset idle ready", up_ready_o, 1);

    // R12 configuration takes effect only after its registering edge
    mst_ns_i = 0; err_mode_i = 0;
    @(negedge clk);
    @(negedge clk);
    mst_ns_i = 1;
    xact(32'h4000, 0, 2'd2, 0, 0, 0, 0, 0, 64'h22, fwd, sec, err, rd, hold_ok, lk_ok, pass_ok);
    chk("R12 old secure setting used", fwd, 1);
    chk("R12 old secure tag", sec, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule